// File: doc/BRIEF.md
# Scaled Effective Address Generator

This block forms the memory address of an operand from up to three terms: a base register value, an index register value shifted left by a 2-bit scale code (factor 1, 2, 4 or 8), and a signed displacement that is sign-extended to the address width. Each register term has its own enable, so the same datapath covers direct addressing (displacement only), register indirect, based, indexed and based-indexed forms. Arithmetic wraps at 32 bits in wide mode and at 16 bits in narrow mode.

In narrow mode only four of the eight general registers may be used for an address term. Any other selection, or a reserved operation code, is reported as an illegal operand, and no memory request goes out. A load or store raises a memory request carrying the address. A load-address operation returns the address as a result value and never raises a memory request. All results appear one clock after the request, qualified by a valid strobe.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and until the first request after it, res_valid, mem_req, mem_write, lea_res and bad_operand are 0 and ea_out is 0.
- R2: A request accepted with in_valid=1 at a rising edge produces res_valid=1 and its results on the outputs right after that edge (one cycle latency); back-to-back requests each produce their own result.
- R3: In wide mode (narrow_mode=0) ea_out = base + (index << scale) + sign-extended disp, modulo 2^32, where scale 0,1,2,3 selects factor 1,2,4,8.
- R4: A term whose enable (base_en or idx_en) is 0 contributes zero regardless of its value; with both disabled ea_out is the sign-extended displacement alone.
- R5: In narrow mode (narrow_mode=1) ea_out[15:0] is the same sum modulo 2^16 and ea_out[31:16] is 0.
- R6: Register selectors are encoded 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI. In narrow mode an enabled base or index term whose selector is not 3, 5, 6 or 7 sets bad_operand; a disabled term's selector is not checked.
- R7: In wide mode every selector 0 to 7 is legal for base and index.
- R8: op_kind is encoded 0=load, 1=store, 2=load-address, 3=reserved. A legal load sets mem_req=1, mem_write=0; a legal store sets mem_req=1, mem_write=1; a legal load-address sets lea_res=1, mem_req=0, mem_write=0. Reserved op_kind sets bad_operand.
- R9: When bad_operand is 1, mem_req, mem_write and lea_res are 0; ea_out still carries the computed address.
- R10: A cycle with in_valid=0 gives res_valid, mem_req, mem_write, lea_res and bad_operand all 0 after the next edge, and ea_out keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| narrow_mode | input | 1 | 1 = 16-bit address mode, 0 = 32-bit |
| op_kind | input | 2 | 0 load, 1 store, 2 load-address, 3 reserved |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register selector |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 3 | Index register selector |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Index shift amount (factor 1/2/4/8) |
| disp | input | 16 | Signed displacement |
| res_valid | output | 1 | Results valid |
| ea_out | output | 32 | Computed address |
| lea_res | output | 1 | Address returned as data |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | Request is a store |
| bad_operand | output | 1 | Illegal operand combination |

## Verification
The assertions take for granted that in_valid, op_kind and the operand inputs are known (not X) at every rising edge after reset, and that in_valid is low while reset is applied so the first valid result follows a real request. The stimulus drives every input on the falling edge from named tasks, keeps in_valid at 0 through reset, and only ever issues fully defined operand sets, so the latency, hold and exclusivity properties see clean values. Expected addresses are computed with a multiply by the scale factor rather than a shift, so the shift datapath is checked against an independent formula.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LEA   = 2'd2,
    OP_RSV   = 2'd3
  } op_kind_e;

  localparam logic [SEL_W-1:0] REG_BX = 3'd3;
  localparam logic [SEL_W-1:0] REG_BP = 3'd5;
  localparam logic [SEL_W-1:0] REG_SI = 3'd6;
  localparam logic [SEL_W-1:0] REG_DI = 3'd7;

  function automatic logic narrow_sel_ok(input logic [SEL_W-1:0] sel);
    return (sel == REG_BX) || (sel == REG_BP) ||
           (sel == REG_SI) || (sel == REG_DI);
  endfunction
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DISP_W   = 16,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              narrow,
  input  logic              base_en,
  input  logic [AW-1:0]     base_val,
  input  logic              idx_en,
  input  logic [AW-1:0]     idx_val,
  input  logic [1:0]        scale,
  input  logic [DISP_W-1:0] disp,
  output logic [AW-1:0]     ea
);
  localparam int unsigned EXT_W = AW - DISP_W;
  localparam int unsigned HI_W  = AW - NARROW_W;

  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] full_sum;

  always_comb begin
    base_term = base_en ? base_val : '0;
    // scaling is a left shift by the 2-bit code
    idx_term  = (idx_en ? idx_val : '0) << scale;
    disp_term = {{EXT_W{disp[DISP_W-1]}}, disp};
    full_sum  = base_term + idx_term + disp_term;
    if (narrow) ea = {{HI_W{1'b0}}, full_sum[NARROW_W-1:0]};
    else        ea = full_sum;
  end
endmodule

// File: rtl/ea_legal.sv
module ea_legal
  import ea_pkg::*;
(
  input  logic             narrow,
  input  logic [OP_W-1:0]  op,
  input  logic             base_en,
  input  logic [SEL_W-1:0] base_sel,
  input  logic             idx_en,
  input  logic [SEL_W-1:0] idx_sel,
  output logic             bad
);
  logic base_bad;
  logic idx_bad;

  always_comb begin
    base_bad = narrow && base_en && !narrow_sel_ok(base_sel);
    idx_bad  = narrow && idx_en  && !narrow_sel_ok(idx_sel);
    bad      = base_bad || idx_bad || (op == OP_RSV);
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DISP_W   = 16,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              narrow_mode,
  input  logic [1:0]        op_kind,
  input  logic              base_en,
  input  logic [2:0]        base_sel,
  input  logic [AW-1:0]     base_val,
  input  logic              idx_en,
  input  logic [2:0]        idx_sel,
  input  logic [AW-1:0]     idx_val,
  input  logic [1:0]        scale,
  input  logic [DISP_W-1:0] disp,
  output logic              res_valid,
  output logic [AW-1:0]     ea_out,
  output logic              lea_res,
  output logic              mem_req,
  output logic              mem_write,
  output logic              bad_operand
);
  localparam int unsigned HI_W = AW - NARROW_W;

  logic          rst_sync_n;
  logic [AW-1:0] ea_comb;
  logic          bad_comb;

  logic          nxt_mem, nxt_wr, nxt_lea, nxt_bad;

  logic          valid_q, mem_q, wr_q, lea_q, bad_q, mode_q;
  logic [AW-1:0] ea_q;

  ea_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ea_sum #(.AW(AW), .DISP_W(DISP_W), .NARROW_W(NARROW_W)) u_sum (
    .narrow   (narrow_mode),
    .base_en  (base_en),
    .base_val (base_val),
    .idx_en   (idx_en),
    .idx_val  (idx_val),
    .scale    (scale),
    .disp     (disp),
    .ea       (ea_comb)
  );

  ea_legal u_legal (
    .narrow   (narrow_mode),
    .op       (op_kind),
    .base_en  (base_en),
    .base_sel (base_sel),
    .idx_en   (idx_en),
    .idx_sel  (idx_sel),
    .bad      (bad_comb)
  );

  always_comb begin
    nxt_bad = in_valid && bad_comb;
    nxt_mem = in_valid && !bad_comb &&
              ((op_kind == OP_LOAD) || (op_kind == OP_STORE));
    nxt_wr  = in_valid && !bad_comb && (op_kind == OP_STORE);
    nxt_lea = in_valid && !bad_comb && (op_kind == OP_LEA);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      lea_q   <= 1'b0;
      bad_q   <= 1'b0;
      mode_q  <= 1'b0;
      ea_q    <= '0;
    end else begin
      valid_q <= in_valid;
      mem_q   <= nxt_mem;
      wr_q    <= nxt_wr;
      lea_q   <= nxt_lea;
      bad_q   <= nxt_bad;
      if (in_valid) begin
        ea_q   <= ea_comb;
        mode_q <= narrow_mode;
      end
    end
  end

  assign res_valid   = valid_q;
  assign ea_out      = ea_q;
  assign lea_res     = lea_q;
  assign mem_req     = mem_q;
  assign mem_write   = wr_q;
  assign bad_operand = bad_q;

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> res_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!res_valid && !mem_req && !lea_res && !bad_operand));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(ea_out));

  // R8
  lea_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_req && lea_res));

  // R8
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_write |-> mem_req);

  // R9
  bad_blocks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_operand |-> (!mem_req && !lea_res && !mem_write));

  // R5
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && mode_q) |-> (ea_out[AW-1:AW-HI_W] == '0));
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        narrow_mode = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        base_en = 1'b0;
  logic [2:0]  base_sel = 3'd0;
  logic [31:0] base_val = 32'd0;
  logic        idx_en = 1'b0;
  logic [2:0]  idx_sel = 3'd0;
  logic [31:0] idx_val = 32'd0;
  logic [1:0]  scale = 2'd0;
  logic [15:0] disp = 16'd0;
  logic        res_valid, lea_res, mem_req, mem_write, bad_operand;
  logic [31:0] ea_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow_mode(narrow_mode),
    .op_kind(op_kind), .base_en(base_en), .base_sel(base_sel), .base_val(base_val),
    .idx_en(idx_en), .idx_sel(idx_sel), .idx_val(idx_val), .scale(scale), .disp(disp),
    .res_valid(res_valid), .ea_out(ea_out), .lea_res(lea_res), .mem_req(mem_req),
    .mem_write(mem_write), .bad_operand(bad_operand)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_ea(input logic nar, input logic be,
      input logic [31:0] bv, input logic ie, input logic [31:0] iv,
      input logic [1:0] sc, input logic [15:0] d);
    logic [31:0] s;
    s = (be ? bv : 32'd0) + (ie ? iv : 32'd0) * (32'd1 << sc)
        + {{16{d[15]}}, d};
    return nar ? (s & 32'h0000_FFFF) : s;
  endfunction

  function automatic logic ok16(input logic [2:0] s);
    return (s == 3'd3) || (s == 3'd5) || (s == 3'd6) || (s == 3'd7);
  endfunction

  // Drives one request at a falling edge and checks it at the next one.
  task automatic xact(input string req, input logic nar, input logic [1:0] op,
      input logic be, input logic [2:0] bs, input logic [31:0] bv,
      input logic ie, input logic [2:0] is, input logic [31:0] iv,
      input logic [1:0] sc, input logic [15:0] d);
    logic bad;
    in_valid = 1'b1; narrow_mode = nar; op_kind = op;
    base_en = be; base_sel = bs; base_val = bv;
    idx_en = ie; idx_sel = is; idx_val = iv; scale = sc; disp = d;
    bad = (op == 2'd3) || (nar && ((be && !ok16(bs)) || (ie && !ok16(is))));
    @(negedge clk);
    chk(req, "res_valid", {31'd0, res_valid}, 32'd1);
    chk(req, "ea_out", ea_out, model_ea(nar, be, bv, ie, iv, sc, d));
    chk(req, "bad_operand", {31'd0, bad_operand}, {31'd0, bad});
    chk(req, "mem_req", {31'd0, mem_req},
        {31'd0, !bad && (op == 2'd0 || op == 2'd1)});
    chk(req, "mem_write", {31'd0, mem_write}, {31'd0, !bad && op == 2'd1});
    chk(req, "lea_res", {31'd0, lea_res}, {31'd0, !bad && op == 2'd2});
  endtask

  task automatic idle_cycle(input string req);
    logic [31:0] held;
    held = ea_out;
    in_valid = 1'b0;
    base_val = 32'hDEAD_BEEF; disp = 16'h7777;
    @(negedge clk);
    chk(req, "idle res_valid", {31'd0, res_valid}, 32'd0);
    chk(req, "idle mem_req", {31'd0, mem_req}, 32'd0);
    chk(req, "idle lea_res", {31'd0, lea_res}, 32'd0);
    chk(req, "idle bad_operand", {31'd0, bad_operand}, 32'd0);
    chk(req, "idle ea_out held", ea_out, held);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1", "res_valid in reset", {31'd0, res_valid}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "ea_out in reset", ea_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R1", "lea_res after reset", {31'd0, lea_res}, 32'd0);
    chk("R1", "bad_operand after reset", {31'd0, bad_operand}, 32'd0);
    chk("R1", "ea_out after reset", ea_out, 32'd0);
  endtask

  task automatic t_scales();
    for (int s = 0; s < 4; s++)
      xact("R3", 1'b0, 2'd0, 1'b1, 3'd0, 32'h1000, 1'b1, 3'd1, 32'd3, s[1:0], 16'h0010);
    chk("R3", "scale 8 literal", ea_out, 32'h0000_1028);
  endtask

  task automatic t_wrap32();
    xact("R3", 1'b0, 2'd0, 1'b1, 3'd2, 32'hFFFF_FFF0, 1'b1, 3'd4, 32'h20, 2'd0, 16'hFFFF);
    chk("R3", "wrap literal", ea_out, 32'h0000_000F);
  endtask

  task automatic t_terms();
    xact("R4", 1'b0, 2'd0, 1'b0, 3'd3, 32'h1234_5678, 1'b0, 3'd6, 32'h0000_0040, 2'd3, 16'h8000);
    chk("R4", "direct literal", ea_out, 32'hFFFF_8000);
    xact("R4", 1'b0, 2'd0, 1'b0, 3'd3, 32'hAAAA_0000, 1'b1, 3'd6, 32'h10, 2'd2, 16'h0004);
    chk("R4", "index only literal", ea_out, 32'h0000_0044);
    xact("R4", 1'b0, 2'd0, 1'b1, 3'd3, 32'h0000_0100, 1'b0, 3'd6, 32'hFFFF_FFFF, 2'd1, 16'h0000);
  endtask

  task automatic t_narrow();
    xact("R5", 1'b1, 2'd0, 1'b1, 3'd3, 32'h0000_FFF0, 1'b1, 3'd6, 32'h20, 2'd0, 16'h0000);
    chk("R5", "narrow wrap literal", ea_out, 32'h0000_0010);
    xact("R5", 1'b1, 2'd1, 1'b1, 3'd5, 32'hABCD_0002, 1'b1, 3'd7, 32'h0000_0001, 2'd1, 16'hFFFE);
  endtask

  task automatic t_legal16();
    xact("R6", 1'b1, 2'd0, 1'b1, 3'd0, 32'h100, 1'b0, 3'd6, 32'h0, 2'd0, 16'h0);
    chk("R6", "AX base illegal", {31'd0, bad_operand}, 32'd1);
    xact("R6", 1'b1, 2'd0, 1'b1, 3'd3, 32'h100, 1'b1, 3'd4, 32'h2, 2'd0, 16'h0);
    chk("R6", "SP index illegal", {31'd0, bad_operand}, 32'd1);
    xact("R6", 1'b1, 2'd0, 1'b0, 3'd1, 32'h100, 1'b1, 3'd6, 32'h2, 2'd0, 16'h0);
    chk("R6", "disabled base unchecked", {31'd0, bad_operand}, 32'd0);
    for (int s = 0; s < 8; s++)
      xact("R6", 1'b1, 2'd2, 1'b1, s[2:0], 32'h40, 1'b0, 3'd0, 32'h0, 2'd0, 16'h1);
  endtask

  task automatic t_legal32();
    for (int s = 0; s < 8; s++) begin
      xact("R7", 1'b0, 2'd0, 1'b1, s[2:0], 32'h40, 1'b1, s[2:0], 32'h1, 2'd3, 16'h0);
      chk("R7", "wide any selector legal", {31'd0, bad_operand}, 32'd0);
    end
  endtask

  task automatic t_ops();
    xact("R8", 1'b0, 2'd2, 1'b1, 3'd6, 32'h0040_0000, 1'b1, 3'd7, 32'h5, 2'd1, 16'hFFFC);
    chk("R8", "lea no request", {31'd0, mem_req}, 32'd0);
    chk("R8", "lea flag", {31'd0, lea_res}, 32'd1);
    xact("R8", 1'b0, 2'd1, 1'b1, 3'd6, 32'h0040_0000, 1'b0, 3'd7, 32'h5, 2'd1, 16'h0008);
    chk("R8", "store write", {31'd0, mem_write}, 32'd1);
    xact("R8", 1'b0, 2'd3, 1'b1, 3'd6, 32'h10, 1'b0, 3'd0, 32'h0, 2'd0, 16'h0);
    chk("R9", "reserved op no request", {31'd0, mem_req}, 32'd0);
    chk("R9", "reserved op address kept", ea_out, 32'h10);
    xact("R9", 1'b1, 2'd1, 1'b1, 3'd2, 32'h10, 1'b0, 3'd0, 32'h0, 2'd0, 16'h0);
    chk("R9", "illegal store no write", {31'd0, mem_write}, 32'd0);
  endtask

  task automatic t_idle();
    xact("R10", 1'b0, 2'd0, 1'b1, 3'd3, 32'h0000_5000, 1'b0, 3'd0, 32'h0, 2'd0, 16'h0021);
    idle_cycle("R10");
    idle_cycle("R10");
    chk("R10", "held literal", ea_out, 32'h0000_5021);
    xact("R2", 1'b0, 2'd0, 1'b1, 3'd3, 32'h1, 1'b0, 3'd0, 32'h0, 2'd0, 16'h1);
    chk("R2", "first after idle", ea_out, 32'h2);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    @(negedge clk);
    t_reset();
    t_scales();
    t_wrap32();
    t_terms();
    t_narrow();
    t_legal16();
    t_legal32();
    t_ops();
    t_idle();
    idle_cycle("R10");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule